// File: doc/BRIEF.md
# Peripheral Interrupt Combiner

This block folds three peripheral event sources into one level interrupt for the main interrupt controller. The sources are a real-time-clock compare match, a timemark tick generator and a power-fail detector. Each source owns a sticky flag that records its event, so the interrupt handler reads one status word to learn which source needs service. It then acknowledges by writing ones to the flags it has handled.

The tick source comes with a mode field that chooses which tick events count. The tick generator reports ordinary ticks, which come roughly every tenth of a second. It also reports ticks whose period it has stretched by a fixed 175 ns. The mode field can count neither, either one or both. The real-time-clock and power-fail sources each have a plain enable bit. That bit masks the interrupt output but does not stop the flag from recording. All event inputs are synchronous to `clk`, and their rising edges are what counts.

Top module: `periph_irq_merge`

## Requirements
- R1: After a synchronous reset, the status word, the control word and `irq_out` are all zero.
- R2: A rising edge on `rtc_match` sets status bit 0. A level that stays high sets it only once, so after it has been cleared the bit stays clear until the next rising edge.
- R3: A rising edge on `pwr_fail` sets status bit 2.
- R4: Control bits [2:1] form the tick mode. 00 records no tick events, 01 records rising edges of `tick_pulse`, 10 records only rising edges of `tick_stretched`, and 11 records both. A recorded tick event sets status bit 1.
- R5: Status bits stay set until a write to address 0 carries a 1 in their position. Bits written as 0 are left unchanged.
- R6: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq_out` is a register that becomes the OR, over all sources, of status bit AND source enable one clock after the status changes. Control bit 0 enables the real-time-clock source, bit 3 enables the power-fail source, and any nonzero tick mode enables the tick source. A disabled source still records its status bit.
- R8: Address 1 holds the 4-bit control word and reads back with all upper bits zero. Address 0 reads the 3 status bits with all upper bits zero. A write to one address leaves the other unchanged. Reads are combinational from `reg_addr`.
- R9: An event input that is already high when reset ends does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 control |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| rtc_match | input | 1 | Real-time-clock compare event |
| tick_pulse | input | 1 | Ordinary tick event |
| tick_stretched | input | 1 | Stretched-period tick event |
| pwr_fail | input | 1 | Power-fail event |
| irq_out | output | 1 | Combined level interrupt |

## Verification
A flag that is lost, duplicated or stuck shows up as soon as the status word is read in the cycle after the event edge. A fault in the output gating shows one clock later on `irq_out`. The bench sweeps every control word against every combination of simultaneous events, so a mode or mask decode error shows for the exact pattern that exposes it. Wrong edge memory shows as a flag that reappears after it has been cleared while its input is held high, or as a flag that gets set by an input that was already high when reset ended.

// File: rtl/pim_pkg.sv
`timescale 1ns/1ps
package pim_pkg;
  localparam int NSRC     = 3;
  localparam int NRAW     = 4;
  localparam int CTL_W    = 4;
  localparam int SRC_RTC  = 0;
  localparam int SRC_TICK = 1;
  localparam int SRC_PWR  = 2;
  localparam int RAW_RTC  = 0;
  localparam int RAW_TICK = 1;
  localparam int RAW_STR  = 2;
  localparam int RAW_PWR  = 3;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_CTL    = 1'b1;

  typedef struct packed {
    logic       pwr_en;
    logic [1:0] tick_mode;
    logic       rtc_en;
  } ctl_t;
endpackage

// File: rtl/pim_edge.sv
`timescale 1ns/1ps
module pim_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // Reset to one so a level already high at reset release is not an edge.
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b1;
      else     prev_q[i] <= din[i];
    end
    assign rise[i] = din[i] & ~prev_q[i];
  end
endmodule

// File: rtl/pim_status.sv
`timescale 1ns/1ps
module pim_status #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;   // set has priority over clear
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/periph_irq_merge.sv
`timescale 1ns/1ps
module periph_irq_merge
  import pim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rtc_match,
  input  logic              tick_pulse,
  input  logic              tick_stretched,
  input  logic              pwr_fail,
  output logic              irq_out
);
  localparam int PAD_S = DATA_W - NSRC;
  localparam int PAD_C = DATA_W - CTL_W;

  logic [NRAW-1:0] raw, rise;
  logic [NSRC-1:0] set_v, clr_v, status_q, mask_v;
  ctl_t            ctl_q;

  assign raw[RAW_RTC]  = rtc_match;
  assign raw[RAW_TICK] = tick_pulse;
  assign raw[RAW_STR]  = tick_stretched;
  assign raw[RAW_PWR]  = pwr_fail;

  pim_edge #(.W(NRAW)) u_edge (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .rise(rise)
  );

  always_comb begin
    set_v           = '0;
    set_v[SRC_RTC]  = rise[RAW_RTC];
    set_v[SRC_TICK] = (rise[RAW_TICK] & ctl_q.tick_mode[0])
                    | (rise[RAW_STR]  & ctl_q.tick_mode[1]);
    set_v[SRC_PWR]  = rise[RAW_PWR];
  end

  assign clr_v = (reg_wr && reg_addr == ADDR_STATUS) ? reg_wdata[NSRC-1:0] : '0;

  pim_status #(.W(NSRC)) u_status (
    .clk  (clk),
    .rst  (rst),
    .set  (set_v),
    .clr  (clr_v),
    .flags(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  ctl_q <= '0;
    else if (reg_wr && reg_addr == ADDR_CTL)  ctl_q <= ctl_t'(reg_wdata[CTL_W-1:0]);
  end

  always_comb begin
    mask_v           = '0;
    mask_v[SRC_RTC]  = ctl_q.rtc_en;
    mask_v[SRC_TICK] = |ctl_q.tick_mode;
    mask_v[SRC_PWR]  = ctl_q.pwr_en;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(status_q & mask_v);
  end

  always_comb begin
    if (reg_addr == ADDR_STATUS) reg_rdata = {{PAD_S{1'b0}}, status_q};
    else                         reg_rdata = {{PAD_C{1'b0}}, ctl_q};
  end
endmodule

// File: rtl/pim_checker.sv
`timescale 1ns/1ps
module pim_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              rtc_match,
  input logic              pwr_fail,
  input logic              irq_out,
  input logic [2:0]        status,
  input logic [3:0]        ctl
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && status == 3'b000 && ctl == 4'b0000));

  assert_rtc_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rtc_match && !$past(rtc_match)) |=> status[0]);

  assert_pwr_edge_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pwr_fail && !$past(pwr_fail)) |=> status[2]);

  assert_tick_off_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl[2:1] == 2'b00 && !status[1]) |=> !status[1]);

  for (genvar i = 0; i < 3; i++) begin : g_sticky
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (status[i] && !(reg_wr && reg_addr == 1'b0 && reg_wdata[i])) |=> status[i]);
  end

  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (status == 3'b000) |=> !irq_out);

  assert_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl == 4'b0000) |=> !irq_out);
endmodule

bind periph_irq_merge pim_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .rtc_match(rtc_match),
  .pwr_fail (pwr_fail),
  .irq_out  (irq_out),
  .status   (status_q),
  .ctl      (ctl_q)
);

// File: tb/periph_irq_merge_test.sv
`timescale 1ns/1ps
module periph_irq_merge_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rtc_match = 1'b0, tick_pulse = 1'b0, tick_stretched = 1'b0, pwr_fail = 1'b0;
  logic       irq_out;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  periph_irq_merge #(.DATA_W(8)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rtc_match(rtc_match), .tick_pulse(tick_pulse),
    .tick_stretched(tick_stretched), .pwr_fail(pwr_fail), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // e: bit0 rtc, bit1 tick, bit2 stretched tick, bit3 power fail
  task automatic drive(input logic [3:0] e);
    rtc_match = e[0]; tick_pulse = e[1]; tick_stretched = e[2]; pwr_fail = e[3];
  endtask

  task automatic pulse(input logic [3:0] e);
    @(negedge clk); drive(e);
    @(negedge clk); drive(4'b0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: inputs high across reset release
    drive(4'b1001);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd_reg(1'b0, rd); check("R1 status after reset", rd, 8'h00);
    rd_reg(1'b1, rd); check("R1 control after reset", rd, 8'h00);
    check("R1 irq after reset", {7'b0, irq_out}, 8'h00);
    rd_reg(1'b0, rd); check("R9 high level at reset release", rd, 8'h00);
    drive(4'b0000);
    pulse(4'b1001);
    rd_reg(1'b0, rd); check("R9 fresh edge after release", rd, 8'h05);
    wr(1'b0, 8'h07);

    // R8: control readback and address isolation
    wr(1'b1, 8'hFF);
    rd_reg(1'b1, rd); check("R8 control readback", rd, 8'h0F);
    wr(1'b0, 8'hFF);
    rd_reg(1'b1, rd); check("R8 status write leaves control", rd, 8'h0F);
    wr(1'b1, 8'h05);
    rd_reg(1'b1, rd); check("R8 control rewrite", rd, 8'h05);
    rd_reg(1'b0, rd); check("R8 control write leaves status", rd, 8'h00);

    // Exhaustive sweep: R2 R3 R4 R7
    for (int c = 0; c < 16; c++) begin
      for (int e = 0; e < 16; e++) begin
        logic [2:0] es;
        logic       ei;
        es[0] = e[0];
        es[1] = (e[1] & c[1]) | (e[2] & c[2]);
        es[2] = e[3];
        ei = (es[0] & c[0]) | (es[1] & (c[1] | c[2])) | (es[2] & c[3]);
        wr(1'b1, 8'(c));
        wr(1'b0, 8'h07);
        @(negedge clk);
        pulse(4'(e));
        rd_reg(1'b0, rd); check("R2 R3 R4 status sweep", rd, {5'b0, es});
        @(negedge clk);
        check("R7 irq sweep", {7'b0, irq_out}, {7'b0, ei});
      end
    end

    // R5: partial clear and write of zero
    wr(1'b1, 8'h0F);
    wr(1'b0, 8'h07);
    pulse(4'b1011);
    rd_reg(1'b0, rd); check("R5 all set", rd, 8'h07);
    wr(1'b0, 8'h02);
    rd_reg(1'b0, rd); check("R5 partial clear", rd, 8'h05);
    wr(1'b0, 8'h00);
    rd_reg(1'b0, rd); check("R5 zero write no effect", rd, 8'h05);
    repeat (5) @(negedge clk);
    rd_reg(1'b0, rd); check("R5 sticky over time", rd, 8'h05);

    // R7: irq registered timing on clear
    wr(1'b0, 8'h07);
    rd_reg(1'b0, rd); check("R7 cleared status", rd, 8'h00);
    check("R7 irq lags clear by one", {7'b0, irq_out}, 8'h01);
    @(negedge clk);
    check("R7 irq drops", {7'b0, irq_out}, 8'h00);

    // R7: disabled source records but does not interrupt
    wr(1'b1, 8'h00);
    pulse(4'b0001);
    @(negedge clk);
    rd_reg(1'b0, rd); check("R7 masked source still records", rd, 8'h01);
    check("R7 masked irq low", {7'b0, irq_out}, 8'h00);
    wr(1'b1, 8'h01);
    @(negedge clk);
    check("R7 enable raises irq", {7'b0, irq_out}, 8'h01);
    wr(1'b0, 8'h07);

    // R2: held level sets once
    @(negedge clk); rtc_match = 1'b1;
    @(negedge clk);
    rd_reg(1'b0, rd); check("R2 level sets", rd, 8'h01);
    wr(1'b0, 8'h01);
    repeat (4) @(negedge clk);
    rd_reg(1'b0, rd); check("R2 held level no re-set", rd, 8'h00);
    rtc_match = 1'b0;
    @(negedge clk);

    // R6: set and clear in the same cycle
    @(negedge clk);
    rtc_match = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h01;
    @(negedge clk);
    rtc_match = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd_reg(1'b0, rd); check("R6 set wins from clear", rd, 8'h01);
    @(negedge clk);
    pwr_fail = 1'b1; rtc_match = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h05;
    @(negedge clk);
    pwr_fail = 1'b0; rtc_match = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd_reg(1'b0, rd); check("R6 set wins when already set", rd, 8'h05);

    // R4: tick mode off ignores both tick inputs
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h00);
    pulse(4'b0110);
    @(negedge clk);
    rd_reg(1'b0, rd); check("R4 tick mode off", rd, 8'h00);
    check("R4 tick mode off irq", {7'b0, irq_out}, 8'h00);

    // R1: reset mid-run clears everything
    pulse(4'b1001);
    wr(1'b1, 8'h0F);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_reg(1'b0, rd); check("R1 status after second reset", rd, 8'h00);
    rd_reg(1'b1, rd); check("R1 control after second reset", rd, 8'h00);
    check("R1 irq after second reset", {7'b0, irq_out}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule